// File: doc/BRIEF.md
# Swept-Response XY Display Sequencer

This block holds the results of a frequency sweep and turns them into a pair of DAC codes for an oscilloscope in XY mode. While a sweep runs, each measured point arrives with its index, one amplitude word and one phase word. The block writes both words into a pair of on-chip memories, one per quantity. When the sweep controller pulses `sweep_done`, the freshly written data becomes the displayed curve.

The curve is then replayed without end. X is a sawtooth whose code rises from zero to full scale across the active points. Y carries the stored value of the point that X shows, from the amplitude memory or the phase memory as `ch_sel` picks. Y is converted to offset binary, so mid-code stands for zero volts. After the last point, `blank` is raised for a fixed retrace time, with X parked at zero.

Each memory has two banks. A new sweep fills the hidden bank while the previous curve stays on screen. The roles of the two banks swap only on `sweep_done`.

Top module: `sweep_xy_display`

## Requirements
- R1: A point is accepted in every cycle where `wr_valid` is high. `wr_ready` stays high, so there is no back-pressure. The point's amplitude and phase words are stored at `wr_idx` in the hidden bank.
- R2: From reset until the first `sweep_done`, the outputs sit at `blank`=1, `x_code`=0 and `y_code`=2048.
- R3: On `sweep_done`, the hidden bank becomes the displayed bank. The point count N and the hold H are captured at the same edge. A `pt_count` of 0 counts as 1, and a value above 256 counts as 256. A `hold_clks` of 0 counts as 1. A write in the same cycle as `sweep_done` belongs to the sweep being completed.
- R4: After `sweep_done`, the outputs are blanked from the second following cycle. Point 0 of the new curve appears 14 cycles after the `sweep_done` cycle. A `sweep_done` that arrives during that wait restarts it.
- R5: For point k, `x_code` = floor(k*4095/(N-1)), so the last point reaches 4095. When N=1, `x_code` is 0.
- R6: `y_code` is the stored word of the displayed point with its top bit inverted: two's complement in memory, offset binary out. `ch_sel`=0 selects amplitude and 1 selects phase. `ch_sel` is sampled every clock, and Y changes in the same cycle as X.
- R7: Each point stays on the outputs for exactly H cycles.
- R8: After the last point, `blank`=1, `x_code`=0 and `y_code`=2048 hold for 4 cycles. The curve then restarts at point 0 and repeats.
- R9: Writes made while a curve is displayed do not change the displayed curve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Point write strobe |
| wr_ready | output | 1 | Always high; no back-pressure |
| wr_idx | input | 8 | Point index of the write |
| wr_amp | input | 12 | Amplitude word, two's complement |
| wr_phase | input | 12 | Phase word, two's complement |
| sweep_done | input | 1 | Pulse that completes a sweep and swaps banks |
| ch_sel | input | 1 | Y source: 0 amplitude, 1 phase |
| pt_count | input | 9 | Number of points in the completed sweep |
| hold_clks | input | 16 | Cycles per displayed point |
| x_code | output | 12 | X DAC code (sawtooth) |
| y_code | output | 12 | Y DAC code, offset binary |
| blank | output | 1 | Retrace or no-curve blank |

## Verification
The hardest state to reach is a bank swap that lands in an awkward spot. That can be a `sweep_done` in the middle of a scan, or a second one while the ramp step is still being computed. At the same moment, writes of a different curve are still flowing into the hidden bank. The stimulus trickles a second sweep's points in between displayed points. It then fires `sweep_done` at chosen offsets into a scan and again a few cycles later. A behavioural model, fed the same inputs, predicts every output on every clock. Clamped counts of 0 and 300 and a full 256-point ramp test the X arithmetic at both extremes.

// File: rtl/xyd_pkg.sv
package xyd_pkg;
  typedef enum logic [1:0] {
    SEQ_EMPTY,
    SEQ_DIV,
    SEQ_SCAN,
    SEQ_RETRACE
  } seq_state_e;
endpackage

// File: rtl/xyd_bank_ram.sv
module xyd_bank_ram #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic              w_bank,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [DATA_W-1:0] w_data,
  input  logic              r_bank,
  input  logic [IDX_W-1:0]  r_idx,
  output logic [DATA_W-1:0] r_data
);
  localparam int WORDS = 2 << IDX_W;

  logic [DATA_W-1:0] mem [WORDS];

  // Banks never collide: the writer owns the hidden bank, the reader the shown one.
  always_ff @(posedge clk) begin
    if (we) mem[{w_bank, w_idx}] <= w_data;
    r_data <= mem[{r_bank, r_idx}];
  end
endmodule

// File: rtl/xyd_divider.sv
module xyd_divider #(
  parameter int NUM_W = 12,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic [DEN_W-1:0] rem,
  output logic             done
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   part;
  logic [NUM_W-1:0] shq;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {part[DEN_W-1:0], shq[NUM_W-1]};
  assign fits  = (trial >= {1'b0, den_q});

  // Restoring division, one quotient bit per cycle, MSB first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      part  <= '0;
      shq   <= '0;
      den_q <= '0;
      done  <= 1'b0;
    end else if (start) begin
      cnt   <= CNT_W'(NUM_W);
      part  <= '0;
      shq   <= num;
      den_q <= den;
      done  <= 1'b0;
    end else if (cnt != '0) begin
      part <= fits ? (trial - {1'b0, den_q}) : trial;
      shq  <= {shq[NUM_W-2:0], fits};
      cnt  <= cnt - 1'b1;
      done <= (cnt == CNT_W'(1));
    end else begin
      done <= 1'b0;
    end
  end

  assign quo = shq;
  assign rem = part[DEN_W-1:0];
endmodule

// File: rtl/xyd_sequencer.sv
module xyd_sequencer
  import xyd_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int DAC_W      = 12,
  parameter int HOLD_W     = 16,
  parameter int BLANK_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              div_done,
  input  logic [DAC_W-1:0]  step_q,
  input  logic [IDX_W-1:0]  step_r,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic [HOLD_W-1:0] hold_m1,
  output logic              scanning,
  output logic [IDX_W-1:0]  pt_idx,
  output logic [DAC_W-1:0]  x_acc
);
  localparam int BL_W = $clog2(BLANK_CLKS) + 1;

  seq_state_e        st;
  logic [HOLD_W-1:0] hold_cnt;
  logic [BL_W-1:0]   bl_cnt;
  logic [IDX_W-1:0]  frac;
  logic [IDX_W:0]    frac_sum;
  logic              carry;

  // Fraction of the ramp step, kept as a running remainder so X stays exact.
  assign frac_sum = {1'b0, frac} + {1'b0, step_r};
  assign carry    = (frac_sum >= {1'b0, last_idx});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SEQ_EMPTY;
      hold_cnt <= '0;
      bl_cnt   <= '0;
      pt_idx   <= '0;
      x_acc    <= '0;
      frac     <= '0;
    end else if (restart) begin
      st <= SEQ_DIV;
    end else begin
      unique case (st)
        SEQ_EMPTY: st <= SEQ_EMPTY;
        SEQ_DIV: begin
          if (div_done) begin
            st       <= SEQ_SCAN;
            pt_idx   <= '0;
            hold_cnt <= '0;
            x_acc    <= '0;
            frac     <= '0;
          end
        end
        SEQ_SCAN: begin
          if (hold_cnt == hold_m1) begin
            hold_cnt <= '0;
            if (pt_idx == last_idx) begin
              st     <= SEQ_RETRACE;
              bl_cnt <= '0;
            end else begin
              pt_idx <= pt_idx + 1'b1;
              if (carry) begin
                frac  <= IDX_W'(frac_sum - {1'b0, last_idx});
                x_acc <= x_acc + step_q + 1'b1;
              end else begin
                frac  <= frac_sum[IDX_W-1:0];
                x_acc <= x_acc + step_q;
              end
            end
          end else begin
            hold_cnt <= hold_cnt + 1'b1;
          end
        end
        SEQ_RETRACE: begin
          if (bl_cnt == BL_W'(BLANK_CLKS - 1)) begin
            st       <= SEQ_SCAN;
            pt_idx   <= '0;
            hold_cnt <= '0;
            x_acc    <= '0;
            frac     <= '0;
          end else begin
            bl_cnt <= bl_cnt + 1'b1;
          end
        end
        default: st <= SEQ_EMPTY;
      endcase
    end
  end

  assign scanning = (st == SEQ_SCAN);
endmodule

// File: rtl/sweep_xy_display.sv
module sweep_xy_display #(
  parameter int IDX_W      = 8,
  parameter int DATA_W     = 12,
  parameter int DAC_W      = 12,
  parameter int HOLD_W     = 16,
  parameter int BLANK_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_amp,
  input  logic [DATA_W-1:0] wr_phase,
  input  logic              sweep_done,
  input  logic              ch_sel,
  input  logic [IDX_W:0]    pt_count,
  input  logic [HOLD_W-1:0] hold_clks,
  output logic [DAC_W-1:0]  x_code,
  output logic [DATA_W-1:0] y_code,
  output logic              blank
);
  localparam int          DEPTH = 1 << IDX_W;
  localparam logic [DAC_W-1:0]  X_FULL = {DAC_W{1'b1}};
  localparam logic [DATA_W-1:0] Y_MID  = {1'b1, {(DATA_W-1){1'b0}}};

  logic              shown_bank;
  logic [IDX_W-1:0]  last_q;
  logic [HOLD_W-1:0] hold_m1_q;
  logic [IDX_W-1:0]  last_new;
  logic [HOLD_W-1:0] hold_m1_new;
  logic [IDX_W:0]    cnt_m1;
  logic [DAC_W-1:0]  step_q;
  logic [IDX_W-1:0]  step_r;
  logic              div_done;
  logic              scanning;
  logic [IDX_W-1:0]  pt_idx;
  logic [DAC_W-1:0]  x_acc;
  logic [DATA_W-1:0] wd [2];
  logic [DATA_W-1:0] rd [2];
  logic              sel_q;
  logic              blank_q;
  logic [DAC_W-1:0]  x_q;
  logic [DATA_W-1:0] y_raw;

  assign wr_ready = 1'b1;

  // Clamp the captured point count into 1..DEPTH and the hold into 1..max.
  assign cnt_m1 = pt_count - 1'b1;
  always_comb begin
    if (pt_count == '0)
      last_new = '0;
    else if (pt_count > (IDX_W+1)'(DEPTH))
      last_new = IDX_W'(DEPTH - 1);
    else
      last_new = cnt_m1[IDX_W-1:0];
  end
  assign hold_m1_new = (hold_clks == '0) ? '0 : hold_clks - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shown_bank <= 1'b0;
      last_q     <= '0;
      hold_m1_q  <= '0;
    end else if (sweep_done) begin
      shown_bank <= ~shown_bank;
      last_q     <= last_new;
      hold_m1_q  <= hold_m1_new;
    end
  end

  assign wd[0] = wr_amp;
  assign wd[1] = wr_phase;

  for (genvar c = 0; c < 2; c++) begin : g_store
    xyd_bank_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
      .clk    (clk),
      .we     (wr_valid),
      .w_bank (~shown_bank),
      .w_idx  (wr_idx),
      .w_data (wd[c]),
      .r_bank (shown_bank),
      .r_idx  (pt_idx),
      .r_data (rd[c])
    );
  end

  xyd_divider #(.NUM_W(DAC_W), .DEN_W(IDX_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sweep_done),
    .num   (X_FULL),
    .den   (last_new),
    .quo   (step_q),
    .rem   (step_r),
    .done  (div_done)
  );

  xyd_sequencer #(
    .IDX_W(IDX_W), .DAC_W(DAC_W), .HOLD_W(HOLD_W), .BLANK_CLKS(BLANK_CLKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (sweep_done),
    .div_done (div_done),
    .step_q   (step_q),
    .step_r   (step_r),
    .last_idx (last_q),
    .hold_m1  (hold_m1_q),
    .scanning (scanning),
    .pt_idx   (pt_idx),
    .x_acc    (x_acc)
  );

  // One output stage, aligned with the memory read so X and Y move together.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b1;
      x_q     <= '0;
      sel_q   <= 1'b0;
    end else begin
      blank_q <= ~scanning;
      x_q     <= scanning ? x_acc : '0;
      sel_q   <= ch_sel;
    end
  end

  assign y_raw  = rd[sel_q];
  assign y_code = blank_q ? Y_MID : {~y_raw[DATA_W-1], y_raw[DATA_W-2:0]};
  assign x_code = x_q;
  assign blank  = blank_q;
endmodule

// File: rtl/xyd_checker.sv
module xyd_checker #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12,
  parameter int DAC_W  = 12,
  parameter int HOLD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sweep_done,
  input logic [IDX_W:0]    pt_count,
  input logic [HOLD_W-1:0] hold_clks,
  input logic [DAC_W-1:0]  x_code,
  input logic [DATA_W-1:0] y_code,
  input logic              blank
);
  localparam logic [DAC_W-1:0]  X_FULL = {DAC_W{1'b1}};
  localparam logic [DATA_W-1:0] Y_MID  = {1'b1, {(DATA_W-1){1'b0}}};

  logic [1:0]      age;
  logic            seen_done;
  logic            one_pt;
  logic [HOLD_W:0] h_lat;
  logic [HOLD_W:0] run;
  logic [DAC_W-1:0] prev_x;
  logic            prev_blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age        <= '0;
      seen_done  <= 1'b0;
      one_pt     <= 1'b0;
      h_lat      <= (HOLD_W+1)'(1);
      run        <= '0;
      prev_x     <= '0;
      prev_blank <= 1'b1;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      if (sweep_done) begin
        seen_done <= 1'b1;
        one_pt    <= (pt_count <= (IDX_W+1)'(1));
        h_lat     <= (hold_clks == '0) ? (HOLD_W+1)'(1) : {1'b0, hold_clks};
      end
      prev_x     <= x_code;
      prev_blank <= blank;
      if (blank || prev_blank || (x_code != prev_x)) run <= (HOLD_W+1)'(1);
      else if (run != '1) run <= run + 1'b1;
    end
  end

  // R2: nothing is shown before the first completed sweep
  a_r2_empty_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_done |-> blank);

  // R8: retrace parks X at zero and Y at mid-code
  a_r8_blank_x_zero: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (x_code == '0));
  a_r8_blank_y_mid: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (y_code == Y_MID));

  // R4: a completed sweep blanks the display two cycles later
  a_r4_done_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> ##2 blank);

  // R5: X never falls inside one ramp
  a_r5_x_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !blank && !$past(blank)) |-> (x_code >= $past(x_code)));

  // R5: a ramp that ends on its own ends at full scale
  a_r5_ramp_top: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $rose(blank) && !$past(sweep_done) && !$past(sweep_done, 2) && !one_pt)
      |-> ($past(x_code) == X_FULL));

  // R7: each point is held for the captured number of cycles
  a_r7_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !blank && !$past(blank) && !$past(sweep_done) && (x_code != $past(x_code)))
      |-> (run == h_lat));
endmodule

bind sweep_xy_display xyd_checker #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .DAC_W(DAC_W), .HOLD_W(HOLD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sweep_done (sweep_done),
  .pt_count   (pt_count),
  .hold_clks  (hold_clks),
  .x_code     (x_code),
  .y_code     (y_code),
  .blank      (blank)
);

// File: tb/sim_sweep_xy_display.sv
`timescale 1ns/1ps
module sim_sweep_xy_display;
  localparam int DEPTH = 256;
  localparam int XFULL = 4095;
  localparam int YMID  = 2048;
  localparam int DIVW  = 12;
  localparam int BLK   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_idx = '0;
  logic [11:0] wr_amp = '0;
  logic [11:0] wr_phase = '0;
  logic        sweep_done = 1'b0;
  logic        ch_sel = 1'b0;
  logic [8:0]  pt_count = '0;
  logic [15:0] hold_clks = '0;
  logic [11:0] x_code;
  logic [11:0] y_code;
  logic        blank;

  always #2 clk = ~clk;

  sweep_xy_display u0 (.*);

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;
  string phase = "R2 idle";

  // Behavioural model: banks[bank][channel][index], state 0 empty 1 wait 2 scan 3 retrace
  int mem [2][2][DEPTH];
  int m_state, m_dl, m_k, m_h, m_bl, m_n, m_hold, m_disp;
  int exp_x, exp_y, exp_b;

  initial begin
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < DEPTH; i++) mem[b][c][i] = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_dl = 0; m_k = 0; m_h = 0; m_bl = 0;
      m_n = 1; m_hold = 1; m_disp = 0;
      exp_x = 0; exp_y = YMID; exp_b = 1;
    end else begin
      exp_b = (m_state != 2);
      exp_x = exp_b ? 0 : ((m_n == 1) ? 0 : (m_k * XFULL) / (m_n - 1));
      exp_y = exp_b ? YMID : (mem[m_disp][ch_sel][m_k] ^ YMID);
      if (wr_valid) begin
        mem[1 - m_disp][0][wr_idx] = wr_amp;
        mem[1 - m_disp][1][wr_idx] = wr_phase;
      end
      if (sweep_done) begin
        m_disp = 1 - m_disp;
        m_n = (pt_count == 0) ? 1 : ((pt_count > DEPTH) ? DEPTH : int'(pt_count));
        m_hold = (hold_clks == 0) ? 1 : int'(hold_clks);
        m_state = 1; m_dl = DIVW;
      end else begin
        case (m_state)
          1: if (m_dl == 0) begin m_state = 2; m_k = 0; m_h = 0; end
             else m_dl--;
          2: if (m_h == m_hold - 1) begin
               m_h = 0;
               if (m_k == m_n - 1) begin m_state = 3; m_bl = 0; end
               else m_k++;
             end else m_h++;
          3: if (m_bl == BLK - 1) begin m_state = 2; m_k = 0; m_h = 0; end
             else m_bl++;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(blank == exp_b[0], "R8 blank", blank, exp_b);
      chk(x_code == exp_x, "R5 x_code", x_code, exp_x);
      chk(y_code == exp_y, "R6 y_code", y_code, exp_y);
      chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
    end
  end

  function automatic int amp_of(int i, int s);
    return (i * 29 + s * 613 + 5) % 4096;
  endfunction
  function automatic int ph_of(int i, int s);
    return ((i * 113) ^ (s * 77)) % 4096;
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(int i, int s);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = 8'(i);
    wr_amp = 12'(amp_of(i, s)); wr_phase = 12'(ph_of(i, s));
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic fill(int n, int s, int gap);
    for (int i = 0; i < n; i++) begin
      put(i, s);
      if (gap > 0) idle(gap);
    end
  endtask

  task automatic finish_sweep(int n, int h);
    @(negedge clk);
    pt_count = 9'(n); hold_clks = 16'(h); sweep_done = 1'b1;
    @(negedge clk);
    sweep_done = 1'b0;
  endtask

  initial begin
    idle(3);
    cmp_en = 1'b1;
    rst_n = 1'b1;
    idle(2);
    // R2: reset state, checked directly as well
    chk(blank == 1'b1, "R2 blank", blank, 1);
    chk(x_code == 0, "R2 x_code", x_code, 0);
    chk(y_code == 12'(YMID), "R2 y_code", y_code, YMID);

    phase = "R1 R2 first fill";
    fill(5, 1, 0);
    idle(10);
    phase = "R3 R4 R7 first curve N=5 H=3";
    finish_sweep(5, 3);
    idle(70);
    ch_sel = 1'b1;
    phase = "R6 phase channel";
    idle(40);

    phase = "R9 second fill during display";
    fill(8, 2, 3);
    idle(20);
    phase = "R3 write in done cycle";
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = 8'd7; wr_amp = 12'd4000; wr_phase = 12'd17;
    pt_count = 9'd8; hold_clks = 16'd2; sweep_done = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; sweep_done = 1'b0;
    phase = "R6 sel toggling";
    for (int t = 0; t < 12; t++) begin
      idle(7);
      ch_sel = ~ch_sel;
    end

    phase = "R5 full 256-point ramp H=0";
    fill(256, 3, 0);
    finish_sweep(256, 0);
    idle(600);

    phase = "R3 count 0 clamps to 1";
    put(0, 4);
    idle(37);
    finish_sweep(0, 0);
    idle(40);

    phase = "R4 done during wait and mid-scan";
    fill(256, 5, 0);
    finish_sweep(300, 2);
    idle(5);
    finish_sweep(300, 2);
    idle(200);
    fill(3, 6, 0);
    finish_sweep(3, 5);
    idle(60);
    phase = "R8 retrace repeats";
    idle(60);

    cmp_en = 1'b0;
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog [%s] actual=%0d expected=%0d", phase, 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule